// File: doc/BRIEF.md
# Phase-Offset Synchronized Clock Divider

This block divides a fast input clock by an integer ratio built from two programmable half-period lengths, one for the high part of the output and one for the low part. A synchronous restart input lets a group of these dividers be realigned together. While the restart input is asserted, every divider parks its output at a programmed start level and clears its counters. When the restart is released, each divider waits its own programmed number of fast-clock cycles before it begins to run.

Giving sibling dividers different delay settings places their outputs at chosen offsets of whole fast-clock periods. Each divider has a 4-bit phase field and a start-level bit. Together they form a 5-bit delay from 0 to 31 cycles, and the start bit contributes 16 of them. All configuration is captured at the restart, so the running waveform never changes in the middle of a period.

Top module: `phsync_clkdiv`

## Requirements
- R1: After reset, and until the first cycle in which `sync` is sampled high, `div_out` is low, whatever the configuration inputs are.
- R2: At every rising clock edge where `sync` is sampled high, `div_out` takes the value of `start_high`, where 1 means high.
- R3: Let the delay be D = 16*`start_high` + `phase_ofs` (0 to 31). Counting edge 1 as the first rising edge with `sync` low, `div_out` keeps its start level through edge D+F-1 and first changes at edge D+F. F is the start-level half length: the high length when `start_high`=1 and the low length otherwise.
- R4: A length field of value f lasts f+1 fast-clock cycles, so 0 gives 1 cycle and 15 gives 16 cycles. After the first change, the output alternates between high for the `hi_len` length and low for the `lo_len` length. The divide ratio is the sum of the two lengths.
- R5: Two dividers with the same settings that share `sync` produce identical outputs on every cycle.
- R6: Two dividers that share `sync` and differ only in their phase fields, by k, produce outputs offset by exactly k cycles: the one with the larger phase repeats the other k cycles later.
- R7: A phase field equal to the divide ratio gives the same steady waveform as a phase of 0. The two outputs are equal from edge D+ratio onward, where D is the larger of the two delays.
- R8: Changes to `hi_len`, `lo_len`, `phase_ofs` and `start_high` while `sync` is low do not alter `div_out`. The values sampled in the last cycle of the restart stay in force.
- R9: A new `sync` pulse while the divider is running restarts it, and the timing of R3 and R4 then applies with the configuration sampled during that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Synchronous restart; holds the output at the start level while high |
| hi_len | input | 4 | High half-period length field (cycles = value + 1) |
| lo_len | input | 4 | Low half-period length field (cycles = value + 1) |
| phase_ofs | input | 4 | Phase delay field, in fast-clock cycles |
| start_high | input | 1 | Start level after restart; also adds 16 cycles of delay |
| div_out | output | 1 | Divided clock output |

## Verification
The hardest situation to reach from the ports is a change of configuration while the divider is mid-period, followed by a second restart, because the old and new settings must each govern the waveform over the right cycles. The bench runs one configuration and checks it cycle by cycle. It rewrites every configuration input between restarts and keeps checking against the old settings. It then fires a new `sync` in the middle of a high phase and checks the output against the new settings. The relative-phase requirements are covered with a second instance that shares `sync`: the bench records the first instance's history and compares the second against it shifted by the phase difference.

// File: rtl/phsync_pkg.sv
package phsync_pkg;

  // Total wait after restart release: start bit weighs 2**ph_w cycles.
  function automatic int unsigned eff_delay(input logic start,
                                            input int unsigned phase,
                                            input int unsigned ph_w);
    return (start ? (32'd1 << ph_w) : 32'd0) + phase;
  endfunction

  // A length field encodes (cycles - 1).
  function automatic int unsigned half_len(input int unsigned field);
    return field + 32'd1;
  endfunction

endpackage

// File: rtl/phsync_delay.sv
module phsync_delay #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic [DW-1:0] load_val,
  output logic          done
);
  logic [DW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (sync)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign done = (remain == '0);
endmodule

// File: rtl/phsync_wave.sv
module phsync_wave
  import phsync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             start_lvl,
  input  logic [CNT_W-1:0] hi_f,
  input  logic [CNT_W-1:0] lo_f,
  input  logic             armed,
  output logic             level,
  output logic             running,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_m1, lo_m1;

  assign hi_m1 = CNT_W'(half_len(32'(hi_f)) - 32'd1);
  assign lo_m1 = CNT_W'(half_len(32'(lo_f)) - 32'd1);

  assign tick = running && armed && !sync && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else if (sync) begin
      level   <= start_lvl;
      running <= 1'b1;
      cnt     <= start_lvl ? hi_m1 : lo_m1;
    end else if (running && armed) begin
      if (cnt == '0) begin
        level <= ~level;
        cnt   <= level ? lo_m1 : hi_m1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/phsync_clkdiv.sv
module phsync_clkdiv
  import phsync_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [PH_W-1:0]  phase_ofs,
  input  logic             start_high,
  output logic             div_out
);
  localparam int DW = PH_W + 1;

  logic [CNT_W-1:0] hi_s, lo_s;
  logic [CNT_W-1:0] hi_use, lo_use;
  logic [DW-1:0]    delay_load;
  logic             phase_done;
  logic             running;
  logic             edge_tick;

  // Length fields are captured during restart; live values feed the load.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_s <= '0;
      lo_s <= '0;
    end else if (sync) begin
      hi_s <= hi_len;
      lo_s <= lo_len;
    end
  end

  assign hi_use     = sync ? hi_len : hi_s;
  assign lo_use     = sync ? lo_len : lo_s;
  assign delay_load = DW'(eff_delay(start_high, 32'(phase_ofs), PH_W));

  phsync_delay #(.DW(DW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync     (sync),
    .load_val (delay_load),
    .done     (phase_done)
  );

  phsync_wave #(.CNT_W(CNT_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (sync),
    .start_lvl (start_high),
    .hi_f      (hi_use),
    .lo_f      (lo_use),
    .armed     (phase_done),
    .level     (div_out),
    .running   (running),
    .tick      (edge_tick)
  );
endmodule

// File: rtl/phsync_clkdiv_chk.sv
module phsync_clkdiv_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync,
  input logic             start_high,
  input logic             div_out,
  input logic             phase_done,
  input logic             running,
  input logic             edge_tick,
  input logic [CNT_W-1:0] hi_s,
  input logic [CNT_W-1:0] lo_s
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !div_out); // R1

  AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (div_out == $past(start_high))); // R2

  AST_HOLD_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !phase_done) |=> $stable(div_out)); // R3

  AST_EDGE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !edge_tick) |=> $stable(div_out)); // R4

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |=> (div_out != $past(div_out))); // R4

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> ($stable(hi_s) && $stable(lo_s))); // R8
endmodule

bind phsync_clkdiv phsync_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync       (sync),
  .start_high (start_high),
  .div_out    (div_out),
  .phase_done (phase_done),
  .running    (running),
  .edge_tick  (edge_tick),
  .hi_s       (hi_s),
  .lo_s       (lo_s)
);

// File: tb/phsync_clkdiv_test.sv
module phsync_clkdiv_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [3:0] hi_len = 4'd0, lo_len = 4'd0;
  logic [3:0] phase_a = 4'd0, phase_b = 4'd0;
  logic       start_high = 1'b0;
  logic       out_a, out_b;

  int checks = 0;
  int errors = 0;
  logic hist [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  phsync_clkdiv uut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .hi_len(hi_len), .lo_len(lo_len),
    .phase_ofs(phase_a), .start_high(start_high), .div_out(out_a));

  phsync_clkdiv uut_b (
    .clk(clk), .rst_n(rst_n), .sync(sync), .hi_len(hi_len), .lo_len(lo_len),
    .phase_ofs(phase_b), .start_high(start_high), .div_out(out_b));

  // Expected level after edge n (n>=1) following restart release.
  function automatic logic exp_level(int n, logic s, int ph, int hf, int lf);
    int d, first, other, t;
    d     = (s ? 16 : 0) + ph;
    first = s ? hf + 1 : lf + 1;
    other = s ? lf + 1 : hf + 1;
    if (n < d + first) return s;
    t = (n - d - first) % (first + other);
    return (t < other) ? ~s : s;
  endfunction

  task automatic check(string req, logic got, logic exp, int n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0b expected %0b", req, n, got, exp);
    end
  endtask

  task automatic do_sync(int len);
    @(negedge clk) sync = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check("R2", out_a, start_high, i);
    end
    sync = 1'b0;
  endtask

  task automatic t_reset();
    start_high = 1'b1; hi_len = 4'd2; lo_len = 4'd1; phase_a = 4'd0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R1", out_a, 1'b0, i);
    end
  endtask

  task automatic t_wave(logic s, int ph, int hf, int lf, int ncyc);
    start_high = s; phase_a = 4'(ph); phase_b = 4'(ph);
    hi_len = 4'(hf); lo_len = 4'(lf);
    do_sync(2);
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      check("R3_R4", out_a, exp_level(n, s, ph, hf, lf), n);
    end
  endtask

  task automatic t_pair_same(logic s, int ph, int hf, int lf);
    start_high = s; phase_a = 4'(ph); phase_b = 4'(ph);
    hi_len = 4'(hf); lo_len = 4'(lf);
    do_sync(1);
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      check("R5", out_b, out_a, n);
    end
  endtask

  task automatic t_pair_skew(int pa, int k, int hf, int lf);
    start_high = 1'b0; phase_a = 4'(pa); phase_b = 4'(pa + k);
    hi_len = 4'(hf); lo_len = 4'(lf);
    do_sync(1);
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      hist[n] = out_a;
      if (n > k) check("R6", out_b, hist[n-k], n);
    end
  endtask

  task automatic t_wrap();
    // divide by 4 (fields 1,1): phase 4 equals phase 0 from edge 8
    start_high = 1'b0; phase_a = 4'd0; phase_b = 4'd4;
    hi_len = 4'd1; lo_len = 4'd1;
    do_sync(1);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n >= 8) check("R7", out_b, out_a, n);
    end
  endtask

  task automatic t_cfg_ignore_and_resync();
    start_high = 1'b0; phase_a = 4'd3; hi_len = 4'd2; lo_len = 4'd4;
    do_sync(1);
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      if (n == 10) begin
        start_high = 1'b1; phase_a = 4'd9; hi_len = 4'd0; lo_len = 4'd7;
      end
      check("R8", out_a, exp_level(n, 1'b0, 3, 2, 4), n);
    end
    // wait until output is high, then restart mid-period
    for (int i = 0; i < 20 && out_a !== 1'b1; i++) @(negedge clk);
    start_high = 1'b1; phase_a = 4'd2; hi_len = 4'd3; lo_len = 4'd0;
    do_sync(1);
    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      check("R9", out_a, exp_level(n, 1'b1, 2, 3, 0), n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    start_high = 1'b0; do_sync(3);
    start_high = 1'b1; do_sync(3);
    t_wave(1'b0, 0, 1, 1, 40);
    t_wave(1'b0, 0, 0, 0, 20);
    t_wave(1'b1, 3, 0, 2, 60);
    t_wave(1'b0, 15, 15, 15, 110);
    t_wave(1'b1, 15, 15, 0, 110);
    t_wave(1'b0, 5, 3, 6, 70);
    t_pair_same(1'b1, 7, 4, 2);
    t_pair_same(1'b0, 0, 0, 5);
    t_pair_skew(0, 1, 1, 1);
    t_pair_skew(0, 2, 1, 1);
    t_pair_skew(3, 7, 5, 2);
    t_wrap();
    t_cfg_ignore_and_resync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule